// File: doc/BRIEF.md
# Marching Cubes Cell Triangulator

This block turns one volume cell per accepted transfer into a stream of surface triangles. A cell arrives as eight corner samples, its integer grid position and a level. Each corner is compared with the level to form an 8-bit case index. A constant table inside the block maps that index to a list of cut corners. Each cut corner becomes one triangle whose three vertices sit at the exact midpoints of the three cube edges that meet at that corner. Vertices are not interpolated by sample value.

Triangles leave one per clock on a valid/ready stream, each tagged with a flag on the final triangle of its cell. While a cell still has triangles pending, the input is held off. The only exception is the cycle in which the final triangle is taken, when the next cell can be accepted at the same time. This keeps the output free of bubbles between cells.

The controller has two states. IDLE waits for a cell. EMIT presents triangles. The transitions are:
- IDLE→EMIT: a cell with at least one triangle is accepted.
- IDLE→IDLE: an empty cell is accepted, or no cell is offered.
- EMIT→EMIT: a non-final triangle is taken, or the final one is taken while a non-empty cell is accepted.
- EMIT→IDLE: the final triangle is taken and no non-empty cell is accepted.

Top module: `mc_cell_triangulator`

## Requirements
- R1: Corner i occupies bits [i*SW +: SW] of `in_corners`. Its case bit i is 1 when its unsigned value is greater than or equal to `in_level`. The corners are numbered in this order by (x,y,z) offset: 0:(0,0,0) 1:(1,0,0) 2:(1,1,0) 3:(0,1,0) 4:(0,0,1) 5:(1,0,1) 6:(1,1,1) 7:(0,1,1).
- R2: The cut set m equals the case index when that index has at most four ones, and its bitwise inverse otherwise. One triangle is emitted for each set bit of m, in ascending corner order, so a cell yields at most four triangles.
- R3: Cases 0x00 and 0xFF are accepted in a single cycle, emit nothing, and leave `in_ready` high.
- R4: For cell (x,y,z) and cut corner offset (a,b,c), the three edge midpoints are:
  - X edge: (2x+1, 2y+2b, 2z+2c)
  - Y edge: (2x+2a, 2y+1, 2z+2c)
  - Z edge: (2x+2a, 2y+2b, 2z+1)
- R5: Vertex v0 is the X-edge midpoint. Normally v1 is the Y edge and v2 is the Z edge. When the case index has more than four ones, v1 and v2 are swapped.
- R6: `out_tri` packs the vertices, from the least significant field up, as v0x, v0y, v0z, v1x, v1y, v1z, v2x, v2y, v2z. Each field is VW=CW+2 bits wide.
- R7: `out_last` is 1 on the final triangle of a cell and 0 on every other triangle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_tri` and `out_last` hold their values.
- R9: `in_ready` is 0 while triangles remain, except in the cycle where the final triangle is taken. In that cycle the next cell is accepted and its first triangle follows with no gap.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.
- R11: The first triangle of an accepted cell is presented in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A cell is offered |
| in_ready | output | 1 | The block takes the offered cell this cycle |
| in_corners | input | 8*SW | Eight corner samples, corner i in bits [i*SW +: SW] |
| in_x | input | CW | Cell grid x |
| in_y | input | CW | Cell grid y |
| in_z | input | CW | Cell grid z |
| in_level | input | SW | Surface level for classification |
| out_valid | output | 1 | A triangle is presented |
| out_ready | input | 1 | The consumer takes the triangle this cycle |
| out_tri | output | 9*VW | Three vertices, nine coordinates |
| out_last | output | 1 | Final triangle of the current cell |

## Verification
The cells tried are:
- Single-corner cases at the grid origin and at the top grid corner. These separate the corner offset table from a wrong shift or a width overflow in the midpoint arithmetic.
- Inverted single-corner cases and a four-corner case. These distinguish the complement rule from a plain popcount, and expose a missing winding swap.
- A corner whose sample equals the level, next to one just below it. This separates greater-or-equal from greater-than.
- Empty cases held back to back, a stalled consumer, and a cell offered while the previous cell's final triangle leaves. These check single-cycle acceptance, output hold, and the gapless hand-over.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int CORNERS   = 8;
    localparam int MAX_CUTS  = 4;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_EMIT = 1'b1
    } tri_state_t;

    // One table row: winding swap, number of cut corners, cut corner ids
    typedef struct packed {
        logic                          flip;
        logic [2:0]                    count;
        logic [MAX_CUTS-1:0][2:0]      corner;
    } case_entry_t;

    function automatic int popcount8(input logic [7:0] v);
        int n;
        n = 0;
        for (int i = 0; i < 8; i++) begin
            if (v[i]) n++;
        end
        return n;
    endfunction

    // Row builder: complement heavy cases, then list the cut corners in ascending order
    function automatic case_entry_t build_entry(input logic [7:0] c);
        case_entry_t e;
        logic [7:0]  m;
        int          n;
        e      = '0;
        e.flip = (popcount8(c) > MAX_CUTS);
        m      = e.flip ? ~c : c;
        n      = 0;
        for (int i = 0; i < CORNERS; i++) begin
            if (m[i] && n < MAX_CUTS) begin
                e.corner[n] = 3'(i);
                n++;
            end
        end
        e.count = 3'(n);
        return e;
    endfunction

endpackage

// File: rtl/mc_classify.sv
module mc_classify #(
    parameter int SW = 8
) (
    input  logic [8*SW-1:0] corners,
    input  logic [SW-1:0]   level,
    output logic [7:0]      case_idx
);

    for (genvar g = 0; g < 8; g++) begin : g_cmp
        assign case_idx[g] = (corners[g*SW +: SW] >= level);
    end

endmodule

// File: rtl/mc_case_rom.sv
module mc_case_rom
    import mc_pkg::*;
(
    input  logic [7:0]  idx,
    output case_entry_t entry
);

    localparam int ROWS = 256;

    case_entry_t rows [ROWS];

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        assign rows[g] = build_entry(8'(g));
    end

    assign entry = rows[idx];

    // R3
    empty_row_chk: assert final ((idx != 8'h00 && idx != 8'hFF) || entry.count == 3'd0);

endmodule

// File: rtl/mc_corner_tri.sv
module mc_corner_tri #(
    parameter int CW = 6,
    parameter int VW = CW + 2
) (
    input  logic [CW-1:0]   x,
    input  logic [CW-1:0]   y,
    input  logic [CW-1:0]   z,
    input  logic [2:0]      corner,
    input  logic            flip,
    output logic [9*VW-1:0] tri_o
);

    logic [VW-1:0] bx, by, bz;
    logic [VW-1:0] fx, fy, fz;
    logic [VW-1:0] ex_x, ex_y, ex_z;
    logic [VW-1:0] ey_x, ey_y, ey_z;
    logic [VW-1:0] ez_x, ez_y, ez_z;
    logic [3*VW-1:0] v0, v1, v2;

    always_comb begin
        bx = VW'(x) << 1;
        by = VW'(y) << 1;
        bz = VW'(z) << 1;
        // far-side offsets for the corner (0 or 2 on each axis)
        fx = (corner[0] ^ corner[1]) ? VW'(2) : '0;
        fy = corner[1]               ? VW'(2) : '0;
        fz = corner[2]               ? VW'(2) : '0;

        ex_x = bx + VW'(1); ex_y = by + fy;      ex_z = bz + fz;
        ey_x = bx + fx;     ey_y = by + VW'(1); ey_z = bz + fz;
        ez_x = bx + fx;     ez_y = by + fy;      ez_z = bz + VW'(1);

        v0 = {ex_z, ex_y, ex_x};
        v1 = flip ? {ez_z, ez_y, ez_x} : {ey_z, ey_y, ey_x};
        v2 = flip ? {ey_z, ey_y, ey_x} : {ez_z, ez_y, ez_x};
        tri_o = {v2, v1, v0};
    end

endmodule

// File: rtl/mc_cell_triangulator.sv
module mc_cell_triangulator
    import mc_pkg::*;
#(
    parameter int SW = 8,
    parameter int CW = 6,
    localparam int VW = CW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [8*SW-1:0] in_corners,
    input  logic [CW-1:0]   in_x,
    input  logic [CW-1:0]   in_y,
    input  logic [CW-1:0]   in_z,
    input  logic [SW-1:0]   in_level,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [9*VW-1:0] out_tri,
    output logic            out_last
);

    tri_state_t  state_q, state_d;
    logic [CW-1:0] px_q, py_q, pz_q;
    case_entry_t ent_q;
    logic [2:0]  idx_q;

    logic [7:0]  case_idx;
    case_entry_t ent_in;
    logic        accept, pop, last_now, in_has_tri;
    logic [2:0]  cur_corner;

    mc_classify #(.SW(SW)) u_cls (
        .corners  (in_corners),
        .level    (in_level),
        .case_idx (case_idx)
    );

    mc_case_rom u_rom (
        .idx   (case_idx),
        .entry (ent_in)
    );

    // handshake terms
    always_comb begin
        last_now   = (idx_q == ent_q.count - 3'd1);
        pop        = out_valid && out_ready;
        in_ready   = (state_q == S_IDLE) || (pop && last_now);
        accept     = in_valid && in_ready;
        in_has_tri = (ent_in.count != 3'd0);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept && in_has_tri) state_d = S_EMIT;
            S_EMIT: if (pop && last_now)
                        state_d = (accept && in_has_tri) ? S_EMIT : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // cell context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px_q  <= '0;
            py_q  <= '0;
            pz_q  <= '0;
            ent_q <= '0;
            idx_q <= '0;
        end else if (accept) begin
            px_q  <= in_x;
            py_q  <= in_y;
            pz_q  <= in_z;
            ent_q <= ent_in;
            idx_q <= '0;
        end else if (pop) begin
            idx_q <= idx_q + 3'd1;
        end
    end

    // outputs
    always_comb begin
        out_valid  = (state_q == S_EMIT);
        out_last   = out_valid && last_now;
        cur_corner = ent_q.corner[idx_q[1:0]];
    end

    mc_corner_tri #(.CW(CW), .VW(VW)) u_tri (
        .x      (px_q),
        .y      (py_q),
        .z      (pz_q),
        .corner (cur_corner),
        .flip   (ent_q.flip),
        .tri_o  (out_tri)
    );

    // checker-side count of triangles taken within the current cell
    logic [2:0] seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n)            seen_q <= '0;
        else if (pop)          seen_q <= out_last ? 3'd0 : seen_q + 3'd1;
    end

    // R2
    tri_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> seen_q < 3'(MAX_CUTS));

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_tri) && $stable(out_last));

    // R9
    hold_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R3
    empty_case_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && in_valid && (case_idx == 8'h00 || case_idx == 8'hFF) |=> !out_valid);

    // R4
    odd_axis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones({out_tri[0], out_tri[VW], out_tri[2*VW]}) == 1
                   && $countones({out_tri[3*VW], out_tri[4*VW], out_tri[5*VW]}) == 1
                   && $countones({out_tri[6*VW], out_tri[7*VW], out_tri[8*VW]}) == 1);

    // R11
    start_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && in_valid && in_ready && case_idx != 8'h00 && case_idx != 8'hFF |=> out_valid);

endmodule

// File: tb/sim_mc_cell_triangulator.sv
`timescale 1ns/1ps
module sim_mc_cell_triangulator;

    localparam int SW = 8;
    localparam int CW = 6;
    localparam int VW = CW + 2;
    localparam int TW = 9 * VW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [8*SW-1:0] in_corners = '0;
    logic [CW-1:0]   in_x = '0, in_y = '0, in_z = '0;
    logic [SW-1:0]   in_level = '0;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [TW-1:0]   out_tri;
    logic            out_last;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mc_cell_triangulator #(.SW(SW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_corners(in_corners), .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .in_level(in_level), .out_valid(out_valid), .out_ready(out_ready),
        .out_tri(out_tri), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Corner offsets in the order given by R1
    function automatic int off_x(input int k); int t[8] = '{0,1,1,0,0,1,1,0}; return t[k]; endfunction
    function automatic int off_y(input int k); int t[8] = '{0,0,1,1,0,0,1,1}; return t[k]; endfunction
    function automatic int off_z(input int k); int t[8] = '{0,0,0,0,1,1,1,1}; return t[k]; endfunction

    // Expected triangle per R4, R5, R6
    function automatic logic [TW-1:0] exp_tri(input int k, input bit flip, input int x, input int y, input int z);
        logic [VW-1:0] a[3], b[3], c[3];
        a[0] = VW'(2*x+1);            a[1] = VW'(2*y+2*off_y(k)); a[2] = VW'(2*z+2*off_z(k));
        b[0] = VW'(2*x+2*off_x(k));   b[1] = VW'(2*y+1);          b[2] = VW'(2*z+2*off_z(k));
        c[0] = VW'(2*x+2*off_x(k));   c[1] = VW'(2*y+2*off_y(k)); c[2] = VW'(2*z+1);
        if (flip) return {b[2], b[1], b[0], c[2], c[1], c[0], a[2], a[1], a[0]};
        return {c[2], c[1], c[0], b[2], b[1], b[0], a[2], a[1], a[0]};
    endfunction

    // Cut list per R2
    task automatic cut_list(input logic [7:0] cs, output int n, output int ks[4], output bit flip);
        logic [7:0] m;
        int pc;
        pc = 0;
        for (int i = 0; i < 8; i++) pc += cs[i];
        flip = (pc > 4);
        m = flip ? ~cs : cs;
        n = 0;
        ks = '{0,0,0,0};
        for (int i = 0; i < 8; i++) if (m[i]) begin ks[n] = i; n++; end
    endtask

    // Sample values: 200 for set bits, 50 otherwise, level 100
    function automatic logic [8*SW-1:0] mk_corners(input logic [7:0] cs);
        logic [8*SW-1:0] v;
        for (int i = 0; i < 8; i++) v[i*SW +: SW] = cs[i] ? 8'd200 : 8'd50;
        return v;
    endfunction

    task automatic put_cell(input logic [8*SW-1:0] cv, input int x, input int y, input int z, input logic [SW-1:0] lv);
        in_corners = cv; in_x = CW'(x); in_y = CW'(y); in_z = CW'(z); in_level = lv;
        in_valid = 1'b1;
    endtask

    // Check the triangle stream of one cell; first sample is the cycle after acceptance
    task automatic expect_cell(input logic [7:0] cs, input int x, input int y, input int z, input string req);
        int n; int ks[4]; bit flip;
        cut_list(cs, n, ks, flip);
        for (int t = 0; t < n; t++) begin
            chk(out_valid === 1'b1, "R11", {req, " valid"}, 128'(out_valid), 128'(1));
            chk(out_tri === exp_tri(ks[t], flip, x, y, z), req, "tri", 128'(out_tri), 128'(exp_tri(ks[t], flip, x, y, z)));
            chk(out_last === (t == n-1), "R7", "last flag", 128'(out_last), 128'(t == n-1));
            @(negedge clk); #1;
        end
    endtask

    task automatic run_single(input logic [7:0] cs, input int x, input int y, input int z, input string req);
        @(negedge clk); #1;
        put_cell(mk_corners(cs), x, y, z, 8'd100);
        chk(in_ready === 1'b1, "R9", "idle ready", 128'(in_ready), 128'(1));
        @(negedge clk); #1;
        in_valid = 1'b0;
        expect_cell(cs, x, y, z, req);
        chk(out_valid === 1'b0, "R7", "drained", 128'(out_valid), 128'(0));
        chk(in_ready === 1'b1, "R9", "ready after drain", 128'(in_ready), 128'(1));
    endtask

    task automatic t_reset();
        #1;
        chk(out_valid === 1'b0, "R10", "out_valid", 128'(out_valid), 128'(0));
        chk(in_ready === 1'b1, "R10", "in_ready", 128'(in_ready), 128'(1));
    endtask

    task automatic t_empty_cases();
        @(negedge clk); #1;
        put_cell(mk_corners(8'h00), 1, 2, 3, 8'd100);
        chk(in_ready === 1'b1, "R3", "case00 ready", 128'(in_ready), 128'(1));
        @(negedge clk); #1;
        chk(out_valid === 1'b0, "R3", "case00 no output", 128'(out_valid), 128'(0));
        put_cell(mk_corners(8'hFF), 4, 5, 6, 8'd100);
        chk(in_ready === 1'b1, "R3", "caseFF ready", 128'(in_ready), 128'(1));
        @(negedge clk); #1;
        in_valid = 1'b0;
        chk(out_valid === 1'b0, "R3", "caseFF no output", 128'(out_valid), 128'(0));
        chk(in_ready === 1'b1, "R3", "ready after empties", 128'(in_ready), 128'(1));
    endtask

    task automatic t_level_equal();
        logic [8*SW-1:0] cv;
        cv = mk_corners(8'h00);
        cv[3*SW +: SW] = 8'd100;
        cv[5*SW +: SW] = 8'd99;
        @(negedge clk); #1;
        put_cell(cv, 7, 8, 9, 8'd100);
        @(negedge clk); #1;
        in_valid = 1'b0;
        expect_cell(8'h08, 7, 8, 9, "R1");
        chk(out_valid === 1'b0, "R1", "single tri for equal corner", 128'(out_valid), 128'(0));
    endtask

    task automatic t_backpressure();
        logic [TW-1:0] held;
        @(negedge clk); #1;
        out_ready = 1'b0;
        put_cell(mk_corners(8'h03), 10, 11, 12, 8'd100);
        @(negedge clk); #1;
        in_valid = 1'b0;
        held = out_tri;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(out_valid === 1'b1 && out_tri === held, "R8", "stall hold", 128'(out_tri), 128'(held));
            chk(in_ready === 1'b0, "R9", "stall not ready", 128'(in_ready), 128'(0));
        end
        out_ready = 1'b1;
        #1;
        expect_cell(8'h03, 10, 11, 12, "R8");
    endtask

    task automatic t_back_to_back();
        @(negedge clk); #1;
        put_cell(mk_corners(8'h01), 2, 3, 4, 8'd100);
        @(negedge clk); #1;
        put_cell(mk_corners(8'h81), 5, 6, 7, 8'd100);
        chk(out_last === 1'b1, "R7", "A last", 128'(out_last), 128'(1));
        chk(in_ready === 1'b1, "R9", "ready on final take", 128'(in_ready), 128'(1));
        chk(out_tri === exp_tri(0, 1'b0, 2, 3, 4), "R9", "A tri", 128'(out_tri), 128'(exp_tri(0, 1'b0, 2, 3, 4)));
        @(negedge clk); #1;
        in_valid = 1'b0;
        expect_cell(8'h81, 5, 6, 7, "R9");
        chk(out_valid === 1'b0, "R9", "drained after B", 128'(out_valid), 128'(0));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_single(8'h01, 0, 0, 0, "R4");
        run_single(8'h40, 63, 63, 63, "R4");
        run_single(8'h80, 3, 1, 2, "R2");
        run_single(8'hFE, 9, 4, 1, "R5");
        run_single(8'h7F, 1, 1, 1, "R5");
        run_single(8'h0F, 20, 30, 40, "R2");
        run_single(8'h5A, 6, 0, 33, "R6");
        t_empty_cases();
        t_level_equal();
        t_backpressure();
        t_back_to_back();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule